// File: doc/BRIEF.md
# Timestamped Run-Length Capture Clusterer

This block sits between a logic-capture front end and a circular, row-organised sample memory. On every event strobe it takes one 16-bit sample word and places it in a cluster. The word is either taken as it is or built by interleaving several fast, narrow samples into one word. A cluster is one 16-bit timestamp followed by seven event words. Each memory row holds 64 clusters. Once a cluster is complete, the block decides whether to store it. A cluster whose events all repeat the last stored word is held back, which gives run-length compression: a reader rebuilds the held-back spans from the gaps between timestamps. A cluster that carries a change, the trigger, or the last cluster before the timestamp gap would overflow is always written.

The block also tracks positions. A stop position and a trigger position are kept as 24-bit row/event pairs. Both point one past the captured location. A sticky round flag shows that the circular memory has wrapped. A force-stop input turns off compression for the rest of the run and raises a post-triggered flag.

The control is a three-state machine. `ST_START` holds until the first cluster is complete. That cluster is always stored, and the `start_done` transition goes to `ST_FILL`, where compression applies. The `stop_req` transition moves from either `ST_START` or `ST_FILL` to `ST_POST` when force-stop is sampled high. `ST_POST` is terminal until reset, and in it every cluster is stored.

Top module: `tsrl_clusterer`

## Requirements
- R1: With `rate_i` = 2, `samp_i[4i+3:4i]` is fast sample i (i = 0..3). Bit k of sample i lands at bit 4k+i of the event word.
- R2: With `rate_i` = 1, `samp_i[8i+7:8i]` is fast sample i (i = 0..1). Bit k of sample i lands at bit 2k+i of the event word.
- R3: With `rate_i` = 0 or 3, the event word equals `samp_i`.
- R4: A stored cluster appears on the write port one cycle after the clock edge that accepted its seventh event, with `mem_we_o` high for one cycle. In `mem_data_o`, bits [15:0] hold the timestamp and bits [16j+31:16j+16] hold event j (j = 0..6). The first write after reset goes to `mem_addr_o` 0, and each later write goes to the next address.
- R5: The timestamp of a cluster is the number of events accepted since reset before its first event, modulo 2^TS_W, zero-extended to 16 bits.
- R6: The first cluster after reset is always stored.
- R7: In `ST_FILL`, a cluster whose seven words all equal the last word of the previous stored cluster is not written. A cluster with any differing word is written.
- R8: After MAX_SKIP = floor((2^TS_W - 1)/7) - 1 clusters have been held back in a row, the next cluster is written regardless of content.
- R9: Force-stop sampled high sets `post_trig_o` from the next cycle until reset. Every cluster completed after that edge is written.
- R10: The first event accepted with `trig_i` high sets `triggered_o` and loads `trig_pos_o` with {write address of the cluster being filled, slot index + 1}, using bits [2:0] for the slot. The cluster containing it is written. Later trigger pulses change neither value.
- R11: `stop_pos_o` holds {address after the last written cluster, 3'b000}, wrapping to 0 after the last address.
- R12: `round_o` goes high when the cluster at the last address of the last row is written and stays high.
- R13: After reset, `mem_we_o`, both positions and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_i | input | 2 | Packing mode: 0/3 plain, 1 two-lane, 2 four-lane |
| evt_i | input | 1 | Event strobe, one sample word accepted per high cycle |
| samp_i | input | 16 | Sample bundle for this event |
| trig_i | input | 1 | Trigger pulse, qualified by `evt_i` |
| force_stop_i | input | 1 | Disable compression and mark post-trigger |
| mem_we_o | output | 1 | Cluster write strobe |
| mem_addr_o | output | ROW_W+CL_W | Cluster address {row, cluster in row} |
| mem_data_o | output | (CL_EV+1)*16 | Timestamp plus event words |
| stop_pos_o | output | 24 | Position after the last written cluster |
| trig_pos_o | output | 24 | Position after the trigger event |
| triggered_o | output | 1 | Trigger seen |
| post_trig_o | output | 1 | Force-stop seen |
| round_o | output | 1 | Circular memory wrapped |

## Verification
The bench builds the block with ROW_W = 2 and TS_W = 8 and leaves CL_W = 6 and CL_EV = 7 at their defaults. That gives 256 cluster slots and MAX_SKIP = 35. With these values, the forced commit at the end of a long run of unchanged pins takes a few hundred events instead of 65 thousand. Likewise, wrapping the whole circular memory and raising the round flag takes under two thousand events.

// File: rtl/tsrl_pkg.sv
package tsrl_pkg;
    localparam int WORD_W = 16;
    localparam int POS_W  = 24;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_FILL  = 2'd1,
        ST_POST  = 2'd2
    } tsrl_state_e;

    typedef enum logic [1:0] {
        RATE_BASE  = 2'd0,
        RATE_X2    = 2'd1,
        RATE_X4    = 2'd2,
        RATE_BASE2 = 2'd3
    } tsrl_rate_e;
endpackage

// File: rtl/tsrl_ilv.sv
module tsrl_ilv #(
    parameter int W     = 16,
    parameter int LANES = 2
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    localparam int LW = W / LANES;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        for (genvar k = 0; k < LW; k++) begin : g_bit
            assign out_o[k*LANES + i] = in_i[i*LW + k];
        end
    end
endmodule

// File: rtl/tsrl_wrptr.sv
module tsrl_wrptr #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic [PTR_W-1:0] ptr_nx_o,
    output logic             round_o
);
    logic [PTR_W-1:0] ptr_q;
    logic             round_q;

    assign ptr_nx_o = ptr_q + PTR_W'(1);
    assign ptr_o    = ptr_q;
    assign round_o  = round_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            round_q <= 1'b0;
        end else if (adv_i) begin
            ptr_q <= ptr_nx_o;
            if (&ptr_q) round_q <= 1'b1;
        end
    end
endmodule

// File: rtl/tsrl_clusterer.sv
module tsrl_clusterer
    import tsrl_pkg::*;
#(
    parameter int ROW_W = 15,
    parameter int CL_W  = 6,
    parameter int CL_EV = 7,
    parameter int TS_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    rate_i,
    input  logic                          evt_i,
    input  logic [WORD_W-1:0]             samp_i,
    input  logic                          trig_i,
    input  logic                          force_stop_i,
    output logic                          mem_we_o,
    output logic [ROW_W+CL_W-1:0]         mem_addr_o,
    output logic [(CL_EV+1)*WORD_W-1:0]   mem_data_o,
    output logic [POS_W-1:0]              stop_pos_o,
    output logic [POS_W-1:0]              trig_pos_o,
    output logic                          triggered_o,
    output logic                          post_trig_o,
    output logic                          round_o
);
    localparam int SLOT_W   = $clog2(CL_EV + 1);
    localparam int PTR_W    = ROW_W + CL_W;
    localparam int DATA_W   = (CL_EV + 1) * WORD_W;
    localparam int MAX_SKIP = ((1 << TS_W) - 1) / CL_EV - 1;
    localparam int SKIP_W   = $clog2(MAX_SKIP + 1) + 1;

    tsrl_state_e st_q, st_d;

    logic [WORD_W-1:0] lane2_w, lane4_w, word_w;
    logic [WORD_W-1:0] hold_q [CL_EV-1];
    logic [WORD_W-1:0] ref_q;
    logic [SLOT_W-1:0] slot_q;
    logic [TS_W-1:0]   ev_cnt_q, ts_q;
    logic [SKIP_W-1:0] skip_q;
    logic              chg_q, tcl_q, trig_hit_q;
    logic              last_slot, chg_now, trig_now, tcl_now, commit, withhold;
    logic [PTR_W-1:0]  ptr, ptr_nx;
    logic [DATA_W-1:0] data_w;

    tsrl_ilv #(.W(WORD_W), .LANES(2)) u_ilv2 (.in_i(samp_i), .out_o(lane2_w));
    tsrl_ilv #(.W(WORD_W), .LANES(4)) u_ilv4 (.in_i(samp_i), .out_o(lane4_w));

    tsrl_wrptr #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .adv_i(commit),
        .ptr_o(ptr), .ptr_nx_o(ptr_nx), .round_o(round_o)
    );

    // sample packing by rate
    always_comb begin
        unique case (tsrl_rate_e'(rate_i))
            RATE_X2:    word_w = lane2_w;
            RATE_X4:    word_w = lane4_w;
            RATE_BASE,
            RATE_BASE2: word_w = samp_i;
            default:    word_w = samp_i;
        endcase
    end

    // cluster completion and store decision
    always_comb begin
        last_slot = (slot_q == SLOT_W'(CL_EV - 1));
        chg_now   = ((slot_q != '0) && chg_q) || (word_w != ref_q);
        trig_now  = evt_i && trig_i && !trig_hit_q;
        tcl_now   = ((slot_q != '0) && tcl_q) || trig_now;
        commit    = evt_i && last_slot &&
                    (chg_now || tcl_now || (st_q != ST_FILL) ||
                     (skip_q >= SKIP_W'(MAX_SKIP)));
        withhold  = evt_i && last_slot && !commit;
    end

    always_comb begin
        data_w = '0;
        data_w[WORD_W-1:0] = WORD_W'(ts_q);
        for (int j = 0; j < CL_EV - 1; j++)
            data_w[(j+1)*WORD_W +: WORD_W] = hold_q[j];
        data_w[CL_EV*WORD_W +: WORD_W] = word_w;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_START: begin
                if (force_stop_i)  st_d = ST_POST;
                else if (commit)   st_d = ST_FILL;
            end
            ST_FILL:  if (force_stop_i) st_d = ST_POST;
            ST_POST:  st_d = ST_POST;
            default:  st_d = ST_START;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_START;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q      <= '0;
            ev_cnt_q    <= '0;
            ts_q        <= '0;
            skip_q      <= '0;
            chg_q       <= 1'b0;
            tcl_q       <= 1'b0;
            trig_hit_q  <= 1'b0;
            ref_q       <= '0;
            mem_we_o    <= 1'b0;
            mem_addr_o  <= '0;
            mem_data_o  <= '0;
            stop_pos_o  <= '0;
            trig_pos_o  <= '0;
        end else begin
            mem_we_o <= commit;
            if (evt_i) begin
                ev_cnt_q <= ev_cnt_q + TS_W'(1);
                slot_q   <= last_slot ? '0 : slot_q + SLOT_W'(1);
                chg_q    <= chg_now;
                tcl_q    <= tcl_now;
                if (slot_q == '0) ts_q <= ev_cnt_q;
            end
            if (trig_now) begin
                trig_hit_q <= 1'b1;
                trig_pos_o <= POS_W'({ptr, SLOT_W'(slot_q + SLOT_W'(1))});
            end
            if (commit) begin
                mem_addr_o <= ptr;
                mem_data_o <= data_w;
                ref_q      <= word_w;
                skip_q     <= '0;
                stop_pos_o <= POS_W'({ptr_nx, SLOT_W'(0)});
            end else if (withhold) begin
                skip_q <= skip_q + SKIP_W'(1);
            end
        end
    end

    for (genvar j = 0; j < CL_EV - 1; j++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold_q[j] <= '0;
            else if (evt_i && slot_q == SLOT_W'(j))
                hold_q[j] <= word_w;
        end
    end

    always_comb begin
        triggered_o = trig_hit_q;
        post_trig_o = (st_q == ST_POST);
    end
endmodule

// File: rtl/tsrl_clusterer_chk.sv
module tsrl_clusterer_chk #(
    parameter int ROW_W = 15,
    parameter int CL_W  = 6,
    parameter int CL_EV = 7,
    parameter int TS_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    evt_i,
    input logic                    force_stop_i,
    input logic                    mem_we_o,
    input logic [ROW_W+CL_W-1:0]   mem_addr_o,
    input logic [23:0]             stop_pos_o,
    input logic [23:0]             trig_pos_o,
    input logic                    triggered_o,
    input logic                    post_trig_o,
    input logic                    round_o
);
    localparam int PTR_W    = ROW_W + CL_W;
    localparam int SLOT_W   = $clog2(CL_EV + 1);
    localparam int MAX_SKIP = ((1 << TS_W) - 1) / CL_EV - 1;
    localparam int GAP_LIM  = CL_EV * (MAX_SKIP + 1);

    logic [PTR_W-1:0] last_addr_q;
    logic             seen_q;
    int               ev_since_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr_q <= '0;
            seen_q      <= 1'b0;
            ev_since_q  <= 0;
        end else begin
            if (mem_we_o) begin
                last_addr_q <= mem_addr_o;
                seen_q      <= 1'b1;
                ev_since_q  <= evt_i ? 1 : 0;
            end else if (evt_i) begin
                ev_since_q <= ev_since_q + 1;
            end
        end
    end

    assert_we_after_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> $past(evt_i));
    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && seen_q) |-> (mem_addr_o == last_addr_q + PTR_W'(1)));
    assert_gap_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_since_q <= GAP_LIM);
    assert_post_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        force_stop_i |=> post_trig_o);
    assert_post_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        post_trig_o |=> post_trig_o);
    assert_trig_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        triggered_o |=> (triggered_o && $stable(trig_pos_o)));
    assert_stop_tracks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (stop_pos_o == 24'({PTR_W'(mem_addr_o + PTR_W'(1)), SLOT_W'(0)})));
    assert_round_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        round_o |=> round_o);
endmodule

bind tsrl_clusterer tsrl_clusterer_chk #(
    .ROW_W(ROW_W), .CL_W(CL_W), .CL_EV(CL_EV), .TS_W(TS_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .force_stop_i(force_stop_i),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .stop_pos_o(stop_pos_o),
    .trig_pos_o(trig_pos_o), .triggered_o(triggered_o),
    .post_trig_o(post_trig_o), .round_o(round_o)
);

// File: tb/tsrl_clusterer_tb_top.sv
`timescale 1ns/1ps
module tsrl_clusterer_tb_top;
    localparam int ROW_W = 2;
    localparam int CL_W  = 6;
    localparam int CL_EV = 7;
    localparam int TS_W  = 8;
    localparam int MAXSK = ((1 << TS_W) - 1) / CL_EV - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   rate_i = '0;
    logic         evt_i = 1'b0;
    logic [15:0]  samp_i = '0;
    logic         trig_i = 1'b0;
    logic         force_stop_i = 1'b0;
    logic         mem_we_o;
    logic [7:0]   mem_addr_o;
    logic [127:0] mem_data_o;
    logic [23:0]  stop_pos_o, trig_pos_o;
    logic         triggered_o, post_trig_o, round_o;

    always #2.5 clk = ~clk;

    tsrl_clusterer #(.ROW_W(ROW_W), .CL_W(CL_W), .CL_EV(CL_EV), .TS_W(TS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rate_i(rate_i), .evt_i(evt_i), .samp_i(samp_i),
        .trig_i(trig_i), .force_stop_i(force_stop_i), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .stop_pos_o(stop_pos_o),
        .trig_pos_o(trig_pos_o), .triggered_o(triggered_o),
        .post_trig_o(post_trig_o), .round_o(round_o)
    );

    typedef struct {
        logic [7:0]   addr;
        logic [127:0] data;
        string        req;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   finished = 1'b0;

    // reference model state
    int          m_ev = 0;
    logic [15:0] m_ref = '0;
    bit          m_have = 1'b0;
    bit          m_post = 1'b0;
    bit          m_trig = 1'b0;
    int          m_skip = 0;
    logic [7:0]  m_ptr = '0;
    logic [23:0] m_tpos = '0;
    logic [15:0] stim [7];

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pack(input logic [15:0] s, input logic [1:0] r);
        logic [15:0] o;
        o = s;
        if (r == 2'd1) begin
            for (int i = 0; i < 2; i++)
                for (int k = 0; k < 8; k++) o[2*k+i] = s[8*i+k];
        end else if (r == 2'd2) begin
            for (int i = 0; i < 4; i++)
                for (int k = 0; k < 4; k++) o[4*k+i] = s[4*i+k];
        end
        return o;
    endfunction

    // driver: feeds one cluster and pushes the expected write
    task automatic run_cluster(input logic [1:0] r, input int tslot);
        logic [15:0]  w [7];
        logic [127:0] d;
        bit           chg, tcl, commit;
        exp_t         e;
        chg = 1'b0;
        tcl = 1'b0;
        for (int j = 0; j < 7; j++) begin
            w[j] = pack(stim[j], r);
            if (w[j] != m_ref) chg = 1'b1;
        end
        d = '0;
        d[15:0] = {8'h00, 8'(m_ev)};
        for (int j = 0; j < 7; j++) d[16*(j+1) +: 16] = w[j];
        for (int j = 0; j < 7; j++) begin
            rate_i = r;
            samp_i = stim[j];
            evt_i  = 1'b1;
            trig_i = (j == tslot);
            if (j == tslot && !m_trig) begin
                m_trig = 1'b1;
                tcl    = 1'b1;
                m_tpos = 24'({m_ptr, 3'(j + 1)});
            end
            if (j == 6) begin
                commit = !m_have || m_post || chg || tcl || (m_skip >= MAXSK);
                if (commit) begin
                    e.addr = m_ptr;
                    e.data = d;
                    e.req  = !m_have ? "R6" : m_post ? "R9" : tcl ? "R10" : chg ? "R7" : "R8";
                    sbq.push_back(e);
                    m_ptr  = m_ptr + 8'd1;
                    m_ref  = w[6];
                    m_have = 1'b1;
                    m_skip = 0;
                end else begin
                    m_skip++;
                end
            end
            @(negedge clk);
        end
        evt_i  = 1'b0;
        trig_i = 1'b0;
        m_ev  += 7;
    endtask

    task automatic fill_const(input logic [15:0] v);
        for (int j = 0; j < 7; j++) stim[j] = v;
    endtask

    // monitor: pops and compares each write (R1-R5 layout and content)
    always @(negedge clk) begin
        if (rst_n && mem_we_o) begin
            if (sbq.size() == 0) begin
                chk("R7 unexpected write", {120'd0, mem_addr_o}, 128'hx);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk({e.req, " R4 addr"}, {120'd0, mem_addr_o}, {120'd0, e.addr});
                chk({e.req, " R5 data"}, mem_data_o, e.data);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [23:0] sp;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 we",    {127'd0, mem_we_o}, 128'd0);
        chk("R13 stop",  {104'd0, stop_pos_o}, 128'd0);
        chk("R13 tpos",  {104'd0, trig_pos_o}, 128'd0);
        chk("R13 flags", {125'd0, triggered_o, post_trig_o, round_o}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 R3 first cluster always stored, plain word, ts 0
        for (int j = 0; j < 7; j++) stim[j] = 16'h1000 + 16'(j * 16'h0111);
        run_cluster(2'd0, -1);
        chk("R11 stop after first", {104'd0, stop_pos_o}, 128'd8);

        // R7 repeat of last stored word is withheld
        fill_const(stim[6]);
        run_cluster(2'd0, -1);
        @(negedge clk);
        chk("R7 withheld stop", {104'd0, stop_pos_o}, 128'd8);

        // R7 single differing word forces store, R5 ts 14
        stim[3] = 16'hBEEF;
        run_cluster(2'd0, -1);

        // R2 two-lane, R1 four-lane, R3 mode 3
        for (int j = 0; j < 7; j++) stim[j] = 16'h5A00 ^ 16'(j * 16'h1357);
        run_cluster(2'd1, -1);
        for (int j = 0; j < 7; j++) stim[j] = 16'hC3A0 ^ 16'(j * 16'h2469);
        run_cluster(2'd2, -1);
        for (int j = 0; j < 7; j++) stim[j] = 16'h0F0F + 16'(j);
        run_cluster(2'd3, -1);

        // R8 long constant run
        fill_const(16'hA5A5);
        run_cluster(2'd0, -1);
        sp = stop_pos_o;
        for (int n = 0; n < MAXSK; n++) run_cluster(2'd0, -1);
        chk("R8 held back", {104'd0, stop_pos_o}, {104'd0, sp});
        run_cluster(2'd0, -1);
        chk("R8 forced store", {104'd0, stop_pos_o}, {104'd0, 24'({m_ptr, 3'd0})});

        // R10 trigger forces store and records position
        run_cluster(2'd0, 4);
        chk("R10 triggered", {127'd0, triggered_o}, 128'd1);
        chk("R10 tpos", {104'd0, trig_pos_o}, {104'd0, m_tpos});
        sp = stop_pos_o;
        run_cluster(2'd0, 2);
        chk("R10 second trigger ignored", {104'd0, trig_pos_o}, {104'd0, m_tpos});
        chk("R10 second cluster held", {104'd0, stop_pos_o}, {104'd0, sp});

        // R9 force stop
        chk("R9 before", {127'd0, post_trig_o}, 128'd0);
        force_stop_i = 1'b1;
        @(negedge clk);
        force_stop_i = 1'b0;
        m_post = 1'b1;
        chk("R9 post flag", {127'd0, post_trig_o}, 128'd1);
        while (m_ptr != 8'hFF) run_cluster(2'd0, -1);
        chk("R12 not yet", {127'd0, round_o}, 128'd0);
        run_cluster(2'd0, -1);
        chk("R12 round", {127'd0, round_o}, 128'd1);
        chk("R11 stop wrap", {104'd0, stop_pos_o}, 128'd0);
        chk("R9 post sticky", {127'd0, post_trig_o}, 128'd1);

        repeat (3) @(negedge clk);
        chk("R4 pending writes", 128'(sbq.size()), 128'd0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule